// File: doc/BRIEF.md
# SPI Byte Memory Slave Controller

This block is the serial front end of a byte-addressed memory whose writes complete at bus speed. A host talks to it over a four-wire serial link (select, serial clock, data in, data out), plus an active-low pause input and an active-low protect pin. All pins are sampled with the block's own system clock through a synchronizer. Serial-clock edges are recovered from the sampled levels, so the serial clock must run well below the system clock. Clock polarity/phase modes 0 and 3 are both accepted. The host's data is taken on the rising serial-clock edge. Returned data changes after the falling edge, most significant bit first.

Each select frame starts with a one-byte command. Two commands carry no further bytes: set-latch (0x06) and clear-latch (0x04). Two commands act on the status byte: status-read (0x05) and status-write (0x01). Two commands take a two-byte address, high byte first, and then stream data: memory-read (0x03) and memory-write (0x02). Every data byte is stored in the cycle after its eighth bit arrives, and the address then advances. There is no page limit on a burst, and the address wraps from the top of the array to zero.

Writes are guarded in three tiers. The first is the write-enable latch, set in an earlier frame. The second is the block-protect field of the status byte. The third is the protect pin, which locks the status byte when the protect-enable bit is set. The controller runs the states ST_OPCODE, ST_ADDR_HI, ST_ADDR_LO, ST_MEM_RD, ST_MEM_WR, ST_STAT_RD, ST_STAT_WR and ST_SKIP. Deselection returns any state to ST_OPCODE. After a complete byte, ST_OPCODE moves on as follows:
- to ST_ADDR_HI for a read, or for a write with the latch set;
- to ST_STAT_RD for a status read;
- to ST_STAT_WR for a status write with the latch set;
- to ST_SKIP for anything else.

ST_ADDR_HI moves to ST_ADDR_LO. ST_ADDR_LO moves to ST_MEM_WR or ST_MEM_RD. ST_STAT_WR moves to ST_SKIP. The states ST_MEM_RD, ST_MEM_WR, ST_STAT_RD and ST_SKIP hold until the frame ends.

Top module: `spi_fram_slave`

## Requirements
- R1: While select is high, or before any frame, `miso_oe` is low, and the command decoder is back at its first-byte state.
- R2: Modes 0 and 3 both work: `mosi` is taken on rising serial-clock edges, and `miso` shifts out most significant bit first, changing after falling edges.
- R3: Command 0x06 sets the write-enable latch and 0x04 clears it. The latch is visible as status bit 1.
- R4: Command 0x05 returns the status byte {bit7 protect-enable, bits 6:4 zero, bits 3:2 block-protect, bit 1 latch, bit 0 zero}, and repeats it for any further bytes in the frame.
- R5: Command 0x01 followed by a byte loads status bits 7, 3 and 2 from that byte, but only when the latch is set. Otherwise the status byte is unchanged.
- R6: When protect-enable is 1 and `prot_pin_n` is low, a status write leaves the status byte unchanged.
- R7: A memory write (0x02) issued while the latch is clear changes no array byte.
- R8: A memory read (0x03) or write (0x02) takes a 16-bit address, high byte first, of which the low ADDR_W bits are used. Data bytes then stream at consecutive addresses for any burst length, and each written byte is stored on its eighth bit.
- R9: The address wraps from 2^ADDR_W-1 to 0 during a burst.
- R10: Block-protect 01 blocks writes to the top quarter of the array, 10 to the top half, and 11 to all of it. A blocked byte is dropped, but the address still advances.
- R11: The latch clears when select rises after a frame whose memory-write or status-write command was accepted.
- R12: Any other command byte makes the rest of the frame ignored, including a later byte that would otherwise be a valid command.
- R13: While `pause_n` is low, serial-clock edges are ignored and `miso_oe` is low. The frame continues unchanged when `pause_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every serial pin |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock from the host (mode 0 or mode 3) |
| mosi | input | 1 | Serial data from the host |
| pause_n | input | 1 | Active-low pause; freezes the frame |
| prot_pin_n | input | 1 | Active-low protect pin for the status byte |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso`; low means high impedance |

## Verification
The hardest situation to reach from the ports is a pause that falls in the middle of a data byte being returned. Serial-clock toggles during that pause must leave both the bit counter and the output shifter untouched. The stimulus opens a read frame, clocks four bits and drops `pause_n`. It then toggles the serial clock and data pins and checks that `miso_oe` is low. After releasing the pause, it finishes the byte and compares the whole byte with the bench model. The lock case also needs a specific setup: protect-enable is written first, then the pin is pulled low, and only then is a status write with the latch set attempted.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    localparam logic [7:0] OP_WEL_SET = 8'h06;
    localparam logic [7:0] OP_WEL_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_MEM_RD  = 8'h03;
    localparam logic [7:0] OP_MEM_WR  = 8'h02;

    localparam int STAT_PE = 7;
    localparam int STAT_BP_HI = 3;
    localparam int STAT_BP_LO = 2;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_MEM_RD,
        ST_MEM_WR,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_SKIP
    } sfm_state_e;

endpackage

// File: rtl/sfm_sync.sv
module sfm_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sfm_shifter.sv
module sfm_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              selected,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              dout
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
        end else begin
            if (!selected) bit_cnt <= '0;
            else if (rise) bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
            if (rise) rx_sr <= {rx_sr[BYTE_W-3:0], din};
            if (load) tx_sr <= load_byte;
            else if (fall && bit_cnt != '0) tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
    end

    assign byte_done = rise && (bit_cnt == LAST);
    assign rx_byte   = {rx_sr, din};
    assign dout      = tx_sr[BYTE_W-1];
endmodule

// File: rtl/sfm_protect.sv
module sfm_protect #(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bp,
    input  logic              prot_en,
    input  logic              prot_pin_n,
    output logic              wr_block,
    output logic              stat_lock
);
    always_comb begin
        case (bp)
            2'b00:   wr_block = 1'b0;
            2'b01:   wr_block = &addr[ADDR_W-1 -: 2];
            2'b10:   wr_block = addr[ADDR_W-1];
            default: wr_block = 1'b1;
        endcase
    end

    assign stat_lock = prot_en && !prot_pin_n;
endmodule

// File: rtl/sfm_mem_array.sv
module sfm_mem_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/spi_fram_slave.sv
module spi_fram_slave
    import sfm_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic ser_clk,
    input  logic mosi,
    input  logic pause_n,
    input  logic prot_pin_n,
    output logic miso,
    output logic miso_oe
);
    localparam int BYTE_W = 8;
    localparam int HI_W = ADDR_W - BYTE_W;
    localparam int PIN_N = 5;

    // synchronized pins: [4] sel_n, [3] ser_clk, [2] mosi, [1] pause_n, [0] prot_pin_n
    logic [PIN_N-1:0] pins_q;
    logic selected, s_sck, s_mosi, s_pause_n, s_prot_n;
    logic sck_q, sel_q, active, rise, fall;

    sfm_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(5'b10011)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sel_n, ser_clk, mosi, pause_n, prot_pin_n}),
        .q(pins_q)
    );

    assign selected  = !pins_q[4];
    assign s_sck     = pins_q[3];
    assign s_mosi    = pins_q[2];
    assign s_pause_n = pins_q[1];
    assign s_prot_n  = pins_q[0];
    assign active    = selected && s_pause_n;
    assign rise      = active && s_sck && !sck_q;
    assign fall      = active && !s_sck && sck_q;

    sfm_state_e state, state_d;
    logic [ADDR_W-1:0] addr, rd_addr;
    logic [HI_W-1:0]   addr_hi;
    logic [ADDR_W-1:0] addr_full;
    logic wel, wr_frame, prot_en;
    logic [1:0] bp;
    logic byte_done, load_tx, mem_we, wr_block, stat_lock;
    logic [BYTE_W-1:0] rx_byte, tx_byte, mem_rdata, status_byte;

    sfm_shifter #(.BYTE_W(BYTE_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .selected(selected), .rise(rise), .fall(fall),
        .din(s_mosi), .load(load_tx), .load_byte(tx_byte),
        .byte_done(byte_done), .rx_byte(rx_byte), .dout(miso)
    );

    sfm_protect #(.ADDR_W(ADDR_W)) i_prot (
        .addr(addr), .bp(bp), .prot_en(prot_en), .prot_pin_n(s_prot_n),
        .wr_block(wr_block), .stat_lock(stat_lock)
    );

    sfm_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) i_mem (
        .clk(clk), .we(mem_we), .waddr(addr), .wdata(rx_byte),
        .raddr(rd_addr), .rdata(mem_rdata)
    );

    // next-state decision
    always_comb begin
        state_d = state;
        if (!selected) begin
            state_d = ST_OPCODE;
        end else if (byte_done) begin
            unique case (state)
                ST_OPCODE: begin
                    if (rx_byte == OP_MEM_RD)               state_d = ST_ADDR_HI;
                    else if (rx_byte == OP_MEM_WR && wel)   state_d = ST_ADDR_HI;
                    else if (rx_byte == OP_STAT_RD)         state_d = ST_STAT_RD;
                    else if (rx_byte == OP_STAT_WR && wel)  state_d = ST_STAT_WR;
                    else                                    state_d = ST_SKIP;
                end
                ST_ADDR_HI: state_d = ST_ADDR_LO;
                ST_ADDR_LO: state_d = wr_frame ? ST_MEM_WR : ST_MEM_RD;
                ST_STAT_WR: state_d = ST_SKIP;
                default:    state_d = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPCODE;
        else        state <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        addr_full   = {addr_hi, rx_byte};
        rd_addr     = (state == ST_ADDR_LO) ? addr_full : addr;
        status_byte = '0;
        status_byte[STAT_PE] = prot_en;
        status_byte[STAT_BP_HI:STAT_BP_LO] = bp;
        status_byte[1] = wel;
        load_tx = byte_done && (state_d == ST_MEM_RD || state_d == ST_STAT_RD);
        tx_byte = (state_d == ST_STAT_RD) ? status_byte : mem_rdata;
        mem_we  = byte_done && (state == ST_MEM_WR) && !wr_block;
        miso_oe = active;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            sel_q    <= 1'b0;
            wel      <= 1'b0;
            wr_frame <= 1'b0;
            prot_en  <= 1'b0;
            bp       <= 2'b00;
            addr     <= '0;
            addr_hi  <= '0;
        end else begin
            sck_q <= s_sck;
            sel_q <= selected;
            if (!selected && sel_q && wr_frame) wel <= 1'b0;
            if (!selected) wr_frame <= 1'b0;
            if (byte_done) begin
                unique case (state)
                    ST_OPCODE: begin
                        if (rx_byte == OP_WEL_SET) wel <= 1'b1;
                        if (rx_byte == OP_WEL_CLR) wel <= 1'b0;
                        if ((rx_byte == OP_MEM_WR || rx_byte == OP_STAT_WR) && wel)
                            wr_frame <= 1'b1;
                    end
                    ST_ADDR_HI: addr_hi <= rx_byte[HI_W-1:0];
                    ST_ADDR_LO: addr <= wr_frame ? addr_full : addr_full + 1'b1;
                    ST_MEM_RD, ST_MEM_WR: addr <= addr + 1'b1;
                    ST_STAT_WR: begin
                        if (!stat_lock) begin
                            prot_en <= rx_byte[STAT_PE];
                            bp      <= rx_byte[STAT_BP_HI:STAT_BP_LO];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sfm_checks.sv
module sfm_checks
    import sfm_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              selected,
    input logic              sel_q,
    input logic              wr_frame,
    input logic              wel,
    input sfm_state_e        state,
    input logic              byte_done,
    input logic [ADDR_W-1:0] addr,
    input logic              mem_we,
    input logic [1:0]        bp,
    input logic              prot_en,
    input logic              stat_lock
);
    assert_idle_when_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !selected |=> state == ST_OPCODE);

    // consecutive addresses, wrapping at the top (R9 as well)
    assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && (state == ST_MEM_RD || state == ST_MEM_WR))
        |=> addr == $past(addr) + 1'b1);

    assert_write_needs_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);

    assert_full_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bp == 2'b11 |-> !mem_we);

    assert_status_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_lock |=> ($stable(prot_en) && $stable(bp)));

    assert_latch_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!selected && sel_q && wr_frame) |=> !wel);
endmodule

bind spi_fram_slave sfm_checks #(.ADDR_W(ADDR_W)) i_checks (
    .clk(clk), .rst_n(rst_n), .selected(selected), .sel_q(sel_q),
    .wr_frame(wr_frame), .wel(wel), .state(state), .byte_done(byte_done),
    .addr(addr), .mem_we(mem_we), .bp(bp), .prot_en(prot_en), .stat_lock(stat_lock)
);

// File: tb/test_spi_fram_slave.sv
module test_spi_fram_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;
    localparam int AW = 11;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sel_n = 1'b1, ser_clk = 1'b0, mosi = 1'b0, pause_n = 1'b1, prot_pin_n = 1'b1;
    logic miso, miso_oe;

    int n_cmp = 0, n_bad = 0;
    bit mode3 = 1'b0;
    logic [7:0] model [DEPTH];
    bit known [DEPTH];
    bit m_wel = 1'b0, m_pe = 1'b0;
    logic [1:0] m_bp = 2'b00;
    logic [7:0] wbuf [8];
    logic [7:0] st, junk;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fram_slave #(.ADDR_W(AW)) i_spi_fram_slave (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk), .mosi(mosi),
        .pause_n(pause_n), .prot_pin_n(prot_pin_n), .miso(miso), .miso_oe(miso_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {m_pe, 3'b000, m_bp, m_wel, 1'b0};
    endfunction

    function automatic bit blocked(input int a);
        case (m_bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= (DEPTH * 3) / 4;
            2'b10:   return a >= DEPTH / 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            ser_clk = 1'b0; mosi = tx[b];
            tick(HALF);
            rx[b] = miso;
            ser_clk = 1'b1;
            tick(HALF);
        end
    endtask

    task automatic begin_frame();
        ser_clk = mode3;
        tick(2);
        sel_n = 1'b0;
        tick(HALF);
    endtask

    task automatic end_frame();
        ser_clk = mode3;
        tick(HALF);
        sel_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        begin_frame(); xfer(op, d); end_frame();
        if (op == 8'h06) m_wel = 1'b1;
        if (op == 8'h04) m_wel = 1'b0;
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] d;
        begin_frame(); xfer(8'h05, d); xfer(8'h00, s); end_frame();
    endtask

    task automatic wr_status(input logic [7:0] v);
        logic [7:0] d;
        begin_frame(); xfer(8'h01, d); xfer(v, d); end_frame();
        if (m_wel) begin
            if (!(m_pe && !prot_pin_n)) begin
                m_pe = v[7];
                m_bp = v[3:2];
            end
            m_wel = 1'b0;
        end
    endtask

    task automatic mem_write(input int a, input int n);
        logic [7:0] d;
        begin_frame();
        xfer(8'h02, d); xfer(8'(a >> 8), d); xfer(8'(a), d);
        for (int i = 0; i < n; i++) xfer(wbuf[i], d);
        end_frame();
        if (m_wel) begin
            for (int i = 0; i < n; i++) begin
                if (!blocked((a + i) % DEPTH)) begin
                    model[(a + i) % DEPTH] = wbuf[i];
                    known[(a + i) % DEPTH] = 1'b1;
                end
            end
            m_wel = 1'b0;
        end
    endtask

    task automatic mem_read_check(input int a, input int n, input string req);
        logic [7:0] d;
        begin_frame();
        xfer(8'h03, d); xfer(8'(a >> 8), d); xfer(8'(a), d);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, d);
            if (known[(a + i) % DEPTH]) check(req, d, model[(a + i) % DEPTH]);
        end
        end_frame();
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d, rx;
        int a, n;
        for (int i = 0; i < DEPTH; i++) begin model[i] = 8'h00; known[i] = 1'b0; end
        tick(4);
        check("R1 reset oe", miso_oe, 1'b0);
        rst_n = 1'b1;
        tick(4);
        check("R1 idle oe", miso_oe, 1'b0);
        rd_status(st); check("R4 reset status", st, 8'h00);

        // R3 latch set / clear
        cmd1(8'h06); rd_status(st); check("R3 latch set", st, 8'h02);
        cmd1(8'h04); rd_status(st); check("R3 latch clear", st, 8'h00);

        // R8 prefill bursts, then R11 latch dropped
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        cmd1(8'h06); mem_write(12'h5FE, 4);
        wbuf[0] = 8'h55; wbuf[1] = 8'h66; wbuf[2] = 8'h77; wbuf[3] = 8'h88;
        cmd1(8'h06); mem_write(12'h3FE, 4);
        mem_read_check(12'h5FE, 4, "R8 burst");
        mem_read_check(12'h3FE, 4, "R8 burst");
        rd_status(st); check("R11 latch cleared after write", st, exp_status());

        // R7 write without latch
        wbuf[0] = 8'hAA;
        mem_write(12'h5FF, 1);
        mem_read_check(12'h5FE, 4, "R7 no latch");

        // R9 wrap in mode 3, read back in both modes (R2)
        mode3 = 1'b1;
        wbuf[0] = 8'h09; wbuf[1] = 8'h0A; wbuf[2] = 8'h0B; wbuf[3] = 8'h0C;
        cmd1(8'h06); mem_write(DEPTH - 2, 4);
        mode3 = 1'b0;
        mem_read_check(DEPTH - 2, 4, "R9 wrap");
        mode3 = 1'b1;
        mem_read_check(DEPTH - 1, 2, "R2 mode3 read");
        rd_status(st); check("R2 mode3 status", st, exp_status());
        mode3 = 1'b0;

        // R5 status write
        wr_status(8'h8C); rd_status(st); check("R5 no latch", st, 8'h00);
        cmd1(8'h06); wr_status(8'h84); rd_status(st); check("R5 accepted", st, 8'h84);

        // R10 upper quarter
        wbuf[0] = 8'hD1; wbuf[1] = 8'hD2;
        cmd1(8'h06); mem_write(12'h5FF, 2);
        mem_read_check(12'h5FE, 4, "R10 quarter");

        // R6 lock
        prot_pin_n = 1'b0;
        cmd1(8'h06); wr_status(8'h00); rd_status(st); check("R6 locked", st, 8'h84);
        prot_pin_n = 1'b1;
        cmd1(8'h06); wr_status(8'h08); rd_status(st); check("R5 unlocked", st, 8'h08);

        // R10 upper half and whole array
        wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
        cmd1(8'h06); mem_write(12'h3FF, 2);
        mem_read_check(12'h3FE, 4, "R10 half");
        cmd1(8'h06); wr_status(8'h0C);
        wbuf[0] = 8'hF0;
        cmd1(8'h06); mem_write(0, 1);
        mem_read_check(DEPTH - 1, 2, "R10 all");
        cmd1(8'h06); wr_status(8'h00); rd_status(st); check("R5 cleared", st, 8'h00);

        // R12 unknown command swallows the frame
        cmd1(8'h06);
        begin_frame(); xfer(8'hFF, d); xfer(8'h04, d); end_frame();
        rd_status(st); check("R12 ignored", st, 8'h02);
        cmd1(8'h04);

        // R13 pause in the middle of a returned byte
        begin_frame();
        check("R13 oe selected", miso_oe, 1'b1);
        xfer(8'h03, d); xfer(8'h05, d); xfer(8'hFE, d);
        for (int b = 7; b >= 0; b--) begin
            if (b == 3) begin
                pause_n = 1'b0; tick(HALF);
                check("R13 oe paused", miso_oe, 1'b0);
                for (int k = 0; k < 2; k++) begin
                    ser_clk = 1'b0; mosi = ~mosi; tick(HALF);
                    ser_clk = 1'b1; tick(HALF);
                end
                pause_n = 1'b1; tick(HALF);
            end
            ser_clk = 1'b0; mosi = 1'b0; tick(HALF);
            rx[b] = miso;
            ser_clk = 1'b1; tick(HALF);
        end
        check("R13 byte after pause", rx, model[12'h5FE]);
        xfer(8'h00, d); check("R13 next byte", d, model[12'h5FF]);
        end_frame();

        // R8 constrained random bursts
        void'($urandom(32'h5EED1));
        for (int it = 0; it < 16; it++) begin
            mode3 = 1'($urandom % 2);
            a = int'($urandom % DEPTH);
            n = 1 + int'($urandom % 6);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            if ($urandom % 4 != 0) cmd1(8'h06);
            mem_write(a, n);
            mem_read_check(a, n, "R8 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule